// File: doc/BRIEF.md
# Four-Mode Asynchronous/Shift Serial Port

This block is a byte-wide serial port with four frame formats, selected by a two-bit mode field. Software reaches it through a small register window: a control register (mode, receive enable, ninth bits and the two completion flags), a data buffer, and a power-control register whose top bit halves the bit period in the divided modes. A write to the data buffer sends a frame on `txd`. A frame that arrives on `rxd` while receive is enabled is placed in a receive holding register, which is what a buffer read returns.

The bit period comes from one of two sources. The shift mode always uses a fixed division of the core clock. The fixed-rate nine-bit mode divides the core clock by 16 or 32. The two variable-rate modes count pulses on `t1_ovf` (one pulse per overflow of an external timer) and advance one bit per 16 or 32 such pulses. Each direction has its own bit-period counter, which restarts when that direction starts a frame.

Top module: `serial_port_4m`

## Requirements
- R1: After a synchronous active-low reset, the control, power-control and receive-buffer registers read 8'h00 and `txd` is high.
- R2: Register addresses are 0 = control, 1 = data buffer, 2 = power control. Control bits: [7:6] mode (0 shift, 1 eight-bit variable rate, 2 nine-bit fixed rate, 3 nine-bit variable rate), [4] receive enable, [3] transmit ninth bit, [2] received ninth bit, [1] transmit-done flag, [0] receive-done flag. Bit 5 reads 0. Power-control bit 7 is the rate-double bit.
- R3: A write to the data buffer starts a frame on `txd`, sent LSB first. Mode 0 sends the 8 data bits with no framing. Mode 1 sends a low start bit, 8 data bits and a high stop bit. Modes 2 and 3 send a start bit, 8 data bits, the transmit ninth bit and a stop bit. `txd` is high when idle.
- R4: One bit lasts 12 clocks in mode 0. In mode 2 it lasts 32 clocks, or 16 when the rate-double bit is set.
- R5: In modes 1 and 3 one bit lasts 32 `t1_ovf` pulses, or 16 with the rate-double bit set. Without pulses the frame does not advance.
- R6: The transmit-done flag is set on the clock edge that ends the last bit period of the frame. Writing 0 to it clears it.
- R7: In modes 1 to 3, while receive is enabled, a falling edge on `rxd` starts reception. Each bit is sampled once near the middle of its period. At the end of the frame the data byte is loaded into the receive buffer and the receive-done flag is set. The received ninth bit takes the ninth data bit in modes 2 and 3, and the stop bit in mode 1.
- R8: While receive is disabled, activity on `rxd` sets no flag and leaves the receive buffer unchanged.
- R9: In mode 0, reception starts when receive is enabled and the receive-done flag is clear. It samples 8 bits from `rxd`, LSB first, at a 12-clock bit period, and clears the received ninth bit.
- R10: A buffer read returns the last received byte, not a byte written for transmission.
- R11: If the hardware sets a done flag on the same edge as a software control write that clears it, the flag ends up set. The other written bits still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 control, 1 buffer, 2 power control) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on reg_addr |
| t1_ovf | input | 1 | Timer overflow pulse, one clock wide per overflow |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
The collision of interest is a software write to the control register that lands on the same clock edge as the end of a transmit frame, which is when the hardware sets the transmit-done flag. The bench starts a mode-2 frame, counts exactly eleven bit periods, and places a control write that clears both flags and changes receive enable so that it is captured on that final edge. The check then expects the done flag to be set and the new enable value to be present. The table-driven loop also checks every transmitted bit at mid-period, and checks the flag one cycle before and on the closing edge, which fixes the frame length and bit period for each mode.

// File: rtl/sp_pkg.sv
// Package: shared encodings for the four-mode serial port.
// Assumes: register window of four addresses, 8-bit data.
package sp_pkg;

    typedef enum logic [1:0] {
        SP_MODE_SHIFT    = 2'd0,
        SP_MODE_UART8    = 2'd1,
        SP_MODE_UART9_FX = 2'd2,
        SP_MODE_UART9_VR = 2'd3
    } sp_mode_e;

    localparam logic [1:0] SP_ADDR_CTRL = 2'd0;
    localparam logic [1:0] SP_ADDR_BUF  = 2'd1;
    localparam logic [1:0] SP_ADDR_PWR  = 2'd2;

    localparam int SP_FRAME_W = 11;

    // Bit positions inside the control register.
    localparam int CB_RXEN  = 4;
    localparam int CB_TX9   = 3;
    localparam int CB_RX9   = 2;
    localparam int CB_TXF   = 1;
    localparam int CB_RXF   = 0;
    localparam int PB_DBL   = 7;

    // Number of bit periods in one frame of the given mode.
    function automatic logic [3:0] sp_frame_len(input sp_mode_e m);
        case (m)
            SP_MODE_SHIFT: return 4'd8;
            SP_MODE_UART8: return 4'd10;
            default:       return 4'd11;
        endcase
    endfunction

endpackage

// File: rtl/sp_bit_timer.sv
// Module: bit-period divider. Counts enabled step pulses while run is high.
// It gives a mid-bit strobe and an end-of-bit strobe.
// Assumes: period is at least 2 and does not change while run is high.
module sp_bit_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic             step,
    input  logic [CNT_W-1:0] period,
    output logic             mid,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_val;
    logic [CNT_W-1:0] half_val;

    // Compare points derived from the selected period.
    always_comb begin
        last_val = period - CNT_W'(1);
        half_val = (period >> 1) - CNT_W'(1);
    end

    assign mid  = run && step && (cnt == half_val);
    assign wrap = run && step && (cnt == last_val);

    // Step counter, restarted by clear and wrapped at the end of each bit.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (clear)      cnt <= '0;
        else if (run && step) cnt <= wrap ? '0 : cnt + CNT_W'(1);
    end

    // R4/R5: the divider never runs past its period.
    assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < period))
        else $error("bit timer count out of range");

endmodule

// File: rtl/sp_tx.sv
// Module: transmit shifter. It loads a frame on start and shifts one bit
// per end-of-bit strobe, LSB first.
// Assumes: mode is stable during a frame; a new start restarts the frame.
module sp_tx
    import sp_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       data,
    input  logic             bit9,
    input  sp_mode_e         mode,
    input  logic             step,
    input  logic [CNT_W-1:0] period,
    output logic             txd,
    output logic             busy,
    output logic             done_pulse
);
    logic [SP_FRAME_W-1:0] sh;
    logic [SP_FRAME_W-1:0] frame;
    logic [3:0]            bcnt;
    logic                  last;
    logic                  wrap;
    logic                  mid_unused;

    sp_bit_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(start), .run(busy), .step(step),
        .period(period), .mid(mid_unused), .wrap(wrap)
    );

    // Frame image for the selected mode, bit 0 sent first.
    always_comb begin
        case (mode)
            SP_MODE_SHIFT: frame = {3'b111, data};
            SP_MODE_UART8: frame = {1'b1, 1'b1, data, 1'b0};
            default:       frame = {1'b1, bit9, data, 1'b0};
        endcase
    end

    assign last       = (bcnt == sp_frame_len(mode) - 4'd1);
    assign done_pulse = busy && wrap && last;
    assign txd        = busy ? sh[0] : 1'b1;

    // Load on start, shift at each bit end, stop after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '1;
            bcnt <= '0;
            busy <= 1'b0;
        end else if (start) begin
            sh   <= frame;
            bcnt <= '0;
            busy <= 1'b1;
        end else if (wrap) begin
            sh <= {1'b1, sh[SP_FRAME_W-1:1]};
            if (last) busy <= 1'b0;
            else      bcnt <= bcnt + 4'd1;
        end
    end

    // R3: the line holds its level between bit boundaries.
    assert_txd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy && !$past(wrap) && !$past(start)) |-> $stable(txd))
        else $error("txd changed inside a bit period");

    // R6: the frame ends after the done strobe unless restarted.
    assert_done_ends_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_pulse && !start) |=> !busy)
        else $error("transmitter still busy after done");

endmodule

// File: rtl/sp_rx.sv
// Module: receive sampler. It synchronises rxd, detects the frame start
// and samples each bit once at mid-period.
// Assumes: mode is stable while a frame is received.
module sp_rx
    import sp_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd,
    input  logic             enable,
    input  logic             hold_flag,
    input  sp_mode_e         mode,
    input  logic             step,
    input  logic [CNT_W-1:0] period,
    output logic             busy,
    output logic             done_pulse,
    output logic [7:0]       data,
    output logic             bit9
);
    logic                  s1, s2, s3;
    logic                  fall;
    logic                  begin_rx;
    logic                  mid;
    logic                  wrap_unused;
    logic                  last;
    logic                  false_start;
    logic [3:0]            bcnt;
    logic [SP_FRAME_W-1:0] sh;
    logic [SP_FRAME_W-1:0] nxt;

    // Two-flop synchroniser plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= rxd;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign fall     = s3 && !s2;
    assign begin_rx = !busy && enable &&
                      ((mode == SP_MODE_SHIFT) ? !hold_flag : fall);

    sp_bit_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(begin_rx), .run(busy), .step(step),
        .period(period), .mid(mid), .wrap(wrap_unused)
    );

    assign nxt         = {s2, sh[SP_FRAME_W-1:1]};
    assign last        = (bcnt == sp_frame_len(mode) - 4'd1);
    assign false_start = (bcnt == 4'd0) && (mode != SP_MODE_SHIFT) && s2;
    assign done_pulse  = busy && mid && last;

    // Byte and ninth bit extracted from the frame as it completes.
    always_comb begin
        case (mode)
            SP_MODE_SHIFT: begin data = nxt[10:3]; bit9 = 1'b0;    end
            SP_MODE_UART8: begin data = nxt[9:2];  bit9 = nxt[10]; end
            default:       begin data = nxt[8:1];  bit9 = nxt[9];  end
        endcase
    end

    // Frame sequencing: start, mid-bit sampling, completion or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            bcnt <= '0;
            sh   <= '1;
        end else if (begin_rx) begin
            busy <= 1'b1;
            bcnt <= '0;
        end else if (busy && mid) begin
            sh <= nxt;
            if (false_start || last) busy <= 1'b0;
            else                     bcnt <= bcnt + 4'd1;
        end
    end

    // R8: a frame only starts while receive is enabled.
    assert_rx_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(enable))
        else $error("reception started while disabled");

    // R9: shift-mode reception only starts with the done flag clear.
    assert_shift_rx_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && mode == SP_MODE_SHIFT) |-> !$past(hold_flag))
        else $error("shift-mode reception started with flag set");

endmodule

// File: rtl/serial_port_4m.sv
// Module: four-mode serial port top. It holds the control, power-control and
// receive-buffer registers, selects the bit period and step source, and
// connects the transmit and receive engines.
// Assumes: software changes mode or rate only while both directions are idle.
module serial_port_4m
    import sp_pkg::*;
#(
    parameter int DIV_SHIFT = 12,
    parameter int DIV_FAST  = 16,
    parameter int DIV_SLOW  = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       t1_ovf,
    input  logic       rxd,
    output logic       txd
);
    localparam int CNT_W = $clog2(DIV_SLOW + 1);

    sp_mode_e         mode_q;
    logic             rx_en_q, tx9_q, rx9_q, txf_q, rxf_q, dbl_q;
    logic [7:0]       rx_buf_q;
    logic [CNT_W-1:0] period;
    logic             step;
    logic             wr_ctrl, wr_buf, wr_pwr;
    logic             tx_busy, tx_done;
    logic             rx_busy, rx_done, rx_bit9;
    logic [7:0]       rx_data;

    assign wr_ctrl = reg_we && (reg_addr == SP_ADDR_CTRL);
    assign wr_buf  = reg_we && (reg_addr == SP_ADDR_BUF);
    assign wr_pwr  = reg_we && (reg_addr == SP_ADDR_PWR);

    // Bit period and step source for the current mode.
    always_comb begin
        case (mode_q)
            SP_MODE_SHIFT: begin period = CNT_W'(DIV_SHIFT); step = 1'b1; end
            SP_MODE_UART9_FX: begin
                period = dbl_q ? CNT_W'(DIV_FAST) : CNT_W'(DIV_SLOW);
                step   = 1'b1;
            end
            default: begin
                period = dbl_q ? CNT_W'(DIV_FAST) : CNT_W'(DIV_SLOW);
                step   = t1_ovf;
            end
        endcase
    end

    // Control register: software fields, with hardware flag set taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= SP_MODE_SHIFT;
            rx_en_q <= 1'b0;
            tx9_q   <= 1'b0;
            rx9_q   <= 1'b0;
            txf_q   <= 1'b0;
            rxf_q   <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                mode_q  <= sp_mode_e'(reg_wdata[7:6]);
                rx_en_q <= reg_wdata[CB_RXEN];
                tx9_q   <= reg_wdata[CB_TX9];
            end
            if (rx_done)      rx9_q <= rx_bit9;
            else if (wr_ctrl) rx9_q <= reg_wdata[CB_RX9];
            txf_q <= (wr_ctrl ? reg_wdata[CB_TXF] : txf_q) | tx_done;
            rxf_q <= (wr_ctrl ? reg_wdata[CB_RXF] : rxf_q) | rx_done;
        end
    end

    // Power-control register: only the rate-double bit is kept.
    always_ff @(posedge clk) begin
        if (!rst_n)      dbl_q <= 1'b0;
        else if (wr_pwr) dbl_q <= reg_wdata[PB_DBL];
    end

    // Receive holding register, loaded at the end of each received frame.
    always_ff @(posedge clk) begin
        if (!rst_n)       rx_buf_q <= '0;
        else if (rx_done) rx_buf_q <= rx_data;
    end

    // Register read multiplexer.
    always_comb begin
        case (reg_addr)
            SP_ADDR_CTRL: reg_rdata = {mode_q, 1'b0, rx_en_q, tx9_q, rx9_q, txf_q, rxf_q};
            SP_ADDR_BUF:  reg_rdata = rx_buf_q;
            SP_ADDR_PWR:  reg_rdata = {dbl_q, 7'd0};
            default:      reg_rdata = 8'h00;
        endcase
    end

    sp_tx #(.CNT_W(CNT_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .start(wr_buf), .data(reg_wdata), .bit9(tx9_q),
        .mode(mode_q), .step(step), .period(period), .txd(txd), .busy(tx_busy),
        .done_pulse(tx_done)
    );

    sp_rx #(.CNT_W(CNT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .enable(rx_en_q), .hold_flag(rxf_q),
        .mode(mode_q), .step(step), .period(period), .busy(rx_busy),
        .done_pulse(rx_done), .data(rx_data), .bit9(rx_bit9)
    );

    // R3: a buffer write always leaves the transmitter busy.
    assert_buf_write_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_buf |=> tx_busy)
        else $error("buffer write did not start a frame");

    // R11: a transmit completion always leaves the flag set.
    assert_tx_flag_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> txf_q)
        else $error("transmit flag lost");

    // R7: a receive completion loads the buffer and sets the flag.
    assert_rx_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> (rxf_q && rx_buf_q == $past(rx_data)))
        else $error("receive completion not captured");

endmodule

// File: tb/tb_serial_port_4m.sv
module tb_serial_port_4m;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       t1_ovf = 1'b0;
    logic       rxd = 1'b1;
    logic       txd;
    int         ovf_ctl = 0;
    int         n_run = 0;
    int         n_fail = 0;
    logic [7:0] last_rx = 8'h00;

    serial_port_4m dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .t1_ovf(t1_ovf),
        .rxd(rxd), .txd(txd)
    );

    always #5 clk = ~clk;

    // Overflow pulse source: 0 none, 1 every clock, 2 every other clock.
    always @(negedge clk) begin
        if (ovf_ctl == 1)      t1_ovf <= 1'b1;
        else if (ovf_ctl == 2) t1_ovf <= ~t1_ovf;
        else                   t1_ovf <= 1'b0;
    end

    // {mode[1:0], double, ninth, data[7:0]}
    localparam logic [11:0] VECS [0:5] = '{
        12'h0A5, 12'h63C, 12'h481, 12'hB5A, 12'h8F0, 12'hF0F
    };

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic int bit_period(input logic [1:0] m, input logic dbl);
        if (m == 2'd0) return 12;
        return dbl ? 16 : 32;
    endfunction

    function automatic int frame_len(input logic [1:0] m);
        if (m == 2'd0) return 8;
        if (m == 2'd1) return 10;
        return 11;
    endfunction

    function automatic logic frame_bit(input logic [1:0] m, input logic b9,
                                       input logic [7:0] d, input int k);
        if (m == 2'd0) return d[k];
        if (k == 0) return 1'b0;
        if (k <= 8) return d[k-1];
        if (m == 2'd1) return 1'b1;
        if (k == 9) return b9;
        return 1'b1;
    endfunction

    task automatic drive_frame(input logic [1:0] m, input logic b9,
                               input logic [7:0] d, input int p);
        for (int k = 0; k < frame_len(m); k++) begin
            rxd = frame_bit(m, b9, d, k);
            repeat (p) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (2 * p) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); chk(v == 8'h00, "R1 ctrl", v, 0);
        rd(2'd1, v); chk(v == 8'h00, "R1 buffer", v, 0);
        rd(2'd2, v); chk(v == 8'h00, "R1 pwr", v, 0);
        chk(txd == 1'b1, "R1 txd idle", txd, 1);

        ovf_ctl = 1;
        // Vector loop: transmit, then receive the same frame (R2 R3 R4 R5 R6 R7 R9)
        for (int i = 0; i < 6; i++) begin
            logic [1:0] m;
            logic       dbl, b9;
            logic [7:0] d;
            int         p, n, el;
            m = VECS[i][11:10]; dbl = VECS[i][9]; b9 = VECS[i][8]; d = VECS[i][7:0];
            p = bit_period(m, dbl); n = frame_len(m);
            wr(2'd2, {dbl, 7'd0});
            wr(2'd0, {m, 2'b00, b9, 3'b000});
            rd(2'd0, v); chk(v == {m, 2'b00, b9, 3'b000}, "R2 ctrl readback", v, {m, 2'b00, b9, 3'b000});
            wr(2'd1, d);
            el = 0;
            for (int k = 0; k < n; k++) begin
                int tgt;
                tgt = k * p + p / 2;
                repeat (tgt - el) @(negedge clk);
                el = tgt;
                chk(txd == frame_bit(m, b9, d, k), "R3 frame bit", txd, frame_bit(m, b9, d, k));
            end
            repeat (n * p - 1 - el) @(negedge clk);
            rd(2'd0, v); chk(v[1] == 1'b0, "R4 R5 no done before period end", v[1], 0);
            @(negedge clk);
            rd(2'd0, v); chk(v[1] == 1'b1, "R6 done at frame end", v[1], 1);
            chk(txd == 1'b1, "R3 idle after frame", txd, 1);
            wr(2'd0, {m, 6'd0});
            rd(2'd0, v); chk(v[1] == 1'b0, "R6 software clear", v[1], 0);

            // receive the same frame
            wr(2'd0, {m, 2'b01, 4'b0000});
            drive_frame(m, b9, d, p);
            rd(2'd0, v); chk(v[0] == 1'b1, "R7 R9 receive flag", v[0], 1);
            chk(v[2] == ((m == 2'd0) ? 1'b0 : (m == 2'd1) ? 1'b1 : b9),
                "R7 R9 received ninth bit", v[2], (m == 2'd0) ? 0 : (m == 2'd1) ? 1 : b9);
            rd(2'd1, v); chk(v == d, "R7 R9 received byte", v, d);
            last_rx = d;
            wr(2'd0, {m, 6'd0});
        end

        // R8: receive disabled, frame ignored
        wr(2'd2, 8'h80);
        wr(2'd0, 8'h40);
        drive_frame(2'd1, 1'b0, 8'h99, 16);
        rd(2'd0, v); chk(v[0] == 1'b0, "R8 no flag when disabled", v[0], 0);
        rd(2'd1, v); chk(v == last_rx, "R8 buffer unchanged", v, last_rx);

        // R10: transmit write does not alter buffer read
        wr(2'd1, 8'h77);
        rd(2'd1, v); chk(v == last_rx, "R10 buffer returns received byte", v, last_rx);
        repeat (10 * 16 + 4) @(negedge clk);
        rd(2'd1, v); chk(v == last_rx, "R10 buffer after transmit", v, last_rx);
        wr(2'd0, 8'h40);

        // R5: variable-rate mode stalls without overflow pulses
        ovf_ctl = 0;
        @(negedge clk);
        wr(2'd1, 8'hC3);
        repeat (100) @(negedge clk);
        chk(txd == 1'b0, "R5 held in start bit", txd, 0);
        rd(2'd0, v); chk(v[1] == 1'b0, "R5 no done without pulses", v[1], 0);
        ovf_ctl = 2;
        repeat (300) @(negedge clk);
        rd(2'd0, v); chk(v[1] == 1'b0, "R5 half rate not yet done", v[1], 0);
        repeat (40) @(negedge clk);
        rd(2'd0, v); chk(v[1] == 1'b1, "R5 done at half pulse rate", v[1], 1);
        ovf_ctl = 1;
        wr(2'd0, 8'h80);

        // R11: flag set and clearing write on the same edge
        wr(2'd0, 8'h88);
        wr(2'd1, 8'h66);
        repeat (11 * 16 - 2) @(negedge clk);
        wr(2'd0, 8'h90);
        rd(2'd0, v); chk(v == 8'h92, "R11 hardware set wins", v, 8'h92);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule